// File: doc/BRIEF.md
# Residue-Domain Polynomial Activation Unit

This block evaluates a smooth activation function, approximated as a fixed fourth-degree polynomial, on a value carried in residue number form. The input is a set of residue digits, one for each modulus of the channel set. The output is P(x) = A·x⁴ + B·x³ + C·x² + D·x + E in the same residue form. No binary conversion takes place at any point. Each modulus channel has its own copy of the datapath: powers of its digit, products with its coefficient residues, and a modular sum. The channels share no carries and need no knowledge of one another.

The coefficients are residue constants fixed at elaboration, one set per channel. The defaults encode the integer polynomial 3x⁴ + 6x³ + 2x² + 5x + 4 over the moduli {2, 3, 5, 7}. That gives a dynamic range of 210. A valid bit travels with the data through three register stages: powers, coefficient products, and summation. A new operand can be accepted every cycle.

Top module: `respoly_act`

## Requirements
- R1: Channel i occupies bits [3i+2:3i] of both `in_res` and `out_res`. Channel 0 uses modulus 2, channel 1 modulus 3, channel 2 modulus 5 and channel 3 modulus 7.
- R2: Whenever `out_vld` is high, every output digit is smaller than its channel's modulus.
- R3: For an input digit x in channel i with modulus m, the output digit is (3x⁴ + 6x³ + 2x² + 5x + 4) mod m. This holds for all 210 residue combinations.
- R4: A sample accepted with `in_vld` high at a rising edge appears with `out_vld` high exactly three rising edges later. `out_vld` is never high unless `in_vld` was high three edges earlier.
- R5: Changing the digit of one channel leaves the output digits of all other channels unchanged.
- R6: An input digit of 0 yields the constant term E mod m. An input digit of 1 yields the sum of all five coefficients mod m.
- R7: While `rst_n` is low, and after its release until a valid sample has passed through, `out_vld` is low.
- R8: Operands presented on consecutive cycles give one result per cycle, in issue order, with none lost.
- R9: Cycles with `in_vld` low produce cycles with `out_vld` low three edges later. Bubbles keep their place in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_vld | input | 1 | Operand on `in_res` is to be evaluated |
| in_res | input | 12 | Residue digits of x, 3 bits per channel |
| out_vld | output | 1 | Result on `out_res` is valid |
| out_res | output | 12 | Residue digits of P(x), 3 bits per channel |

## Verification
The first pattern is a back-to-back sweep of all 210 integers in residue form. It exercises every digit of every channel, and it separates a correct power or coefficient product from one that differs only for rare digit values. A short table of integers is then issued with idle cycles between entries, which tells a correct valid delay apart from one that drops or shifts bubbles. Sweeps that change one channel's digit while holding the rest fixed show whether any channel leaks into another. Directed x = 0 and x = 1 operands isolate the constant term and the coefficient sum.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
   localparam int unsigned RPA_NCH   = 4;
   localparam int unsigned RPA_RW    = 3;
   localparam int unsigned RPA_STAGES = 3;

   function automatic bit rpa_is_pow2(input int unsigned m);
      return (m != 0) && ((m & (m - 1)) == 0);
   endfunction
endpackage

// File: rtl/rpa_modmul.sv
module rpa_modmul #(
   parameter int unsigned M  = 5,
   parameter int unsigned RW = 3
) (
   input  logic [RW-1:0] a,
   input  logic [RW-1:0] b,
   output logic [RW-1:0] p
);
   localparam int unsigned PW = 2 * RW;
   localparam logic [PW-1:0] MASK = PW'(M - 1);
   localparam logic [PW-1:0] MODV = PW'(M);

   logic [PW-1:0] prod;
   assign prod = PW'(a) * PW'(b);

   generate
      if (rpa_pkg::rpa_is_pow2(M)) begin : g_mask
         assign p = RW'(prod & MASK);
      end else begin : g_rem
         assign p = RW'(prod % MODV);
      end
   endgenerate
endmodule

// File: rtl/rpa_lane.sv
module rpa_lane #(
   parameter int unsigned M            = 5,
   parameter int unsigned RW           = 3,
   parameter int unsigned CA           = 0,
   parameter int unsigned CB           = 0,
   parameter int unsigned CC           = 0,
   parameter int unsigned CD           = 0,
   parameter int unsigned CE           = 0,
   parameter bit          QUAD_FROM_SQ = 1'b1
) (
   input  logic          clk,
   input  logic [RW-1:0] x,
   output logic [RW-1:0] y
);
   localparam int unsigned SW = RW + 3;
   localparam logic [RW-1:0] KA = RW'(CA);
   localparam logic [RW-1:0] KB = RW'(CB);
   localparam logic [RW-1:0] KC = RW'(CC);
   localparam logic [RW-1:0] KD = RW'(CD);
   localparam logic [RW-1:0] KE = RW'(CE);
   localparam logic [SW-1:0] MODS = SW'(M);

   generate
      if (CA >= M || CB >= M || CC >= M || CD >= M || CE >= M) begin : g_bad_coef
         $error("rpa_lane: coefficient residue not below modulus");
      end
   endgenerate

   // stage 1: powers of x
   logic [RW-1:0] sq, cu, qu;
   rpa_modmul #(.M(M), .RW(RW)) u_sq (.a(x),  .b(x), .p(sq));
   rpa_modmul #(.M(M), .RW(RW)) u_cu (.a(sq), .b(x), .p(cu));
   generate
      if (QUAD_FROM_SQ) begin : g_quad_sq
         rpa_modmul #(.M(M), .RW(RW)) u_qu (.a(sq), .b(sq), .p(qu));
      end else begin : g_quad_chain
         rpa_modmul #(.M(M), .RW(RW)) u_qu (.a(cu), .b(x), .p(qu));
      end
   endgenerate

   logic [RW-1:0] p1_q, p2_q, p3_q, p4_q;
   always_ff @(posedge clk) begin
      p1_q <= x;
      p2_q <= sq;
      p3_q <= cu;
      p4_q <= qu;
   end

   // stage 2: coefficient products
   logic [RW-1:0] td, tc, tb, ta;
   rpa_modmul #(.M(M), .RW(RW)) u_td (.a(p1_q), .b(KD), .p(td));
   rpa_modmul #(.M(M), .RW(RW)) u_tc (.a(p2_q), .b(KC), .p(tc));
   rpa_modmul #(.M(M), .RW(RW)) u_tb (.a(p3_q), .b(KB), .p(tb));
   rpa_modmul #(.M(M), .RW(RW)) u_ta (.a(p4_q), .b(KA), .p(ta));

   logic [RW-1:0] td_q, tc_q, tb_q, ta_q;
   always_ff @(posedge clk) begin
      td_q <= td;
      tc_q <= tc;
      tb_q <= tb;
      ta_q <= ta;
   end

   // stage 3: modular sum with constant term
   logic [SW-1:0] acc;
   assign acc = SW'(td_q) + SW'(tc_q) + SW'(tb_q) + SW'(ta_q) + SW'(KE);

   always_ff @(posedge clk) begin
      y <= RW'(acc % MODS);
   end
endmodule

// File: rtl/respoly_act.sv
module respoly_act #(
   parameter int unsigned NCH = rpa_pkg::RPA_NCH,
   parameter int unsigned RW  = rpa_pkg::RPA_RW,
   parameter int unsigned MODS   [NCH] = '{2, 3, 5, 7},
   parameter int unsigned COEF_A [NCH] = '{1, 0, 3, 3},
   parameter int unsigned COEF_B [NCH] = '{0, 0, 1, 6},
   parameter int unsigned COEF_C [NCH] = '{0, 2, 2, 2},
   parameter int unsigned COEF_D [NCH] = '{1, 2, 0, 5},
   parameter int unsigned COEF_E [NCH] = '{0, 1, 4, 4},
   parameter bit          QUAD_FROM_SQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [NCH*RW-1:0] in_res,
   output logic              out_vld,
   output logic [NCH*RW-1:0] out_res
);
   localparam int unsigned DEPTH = rpa_pkg::RPA_STAGES;

   generate
      if (NCH < 1 || RW < 1) begin : g_bad_shape
         $error("respoly_act: channel count and digit width must be positive");
      end
   endgenerate

   // valid pipeline, one bit per stage
   logic [DEPTH-1:0] vpipe;
   always_ff @(posedge clk) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[DEPTH-2:0], in_vld};
   end
   assign out_vld = vpipe[DEPTH-1];

   // R4: valid latency in both directions
   a_r4_vld_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> ##2 out_vld);
   a_r4_vld_back: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld, 3));

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      if (MODS[g] < 2 || MODS[g] > (1 << RW)) begin : g_bad_mod
         $error("respoly_act: modulus does not fit the digit width");
      end

      rpa_lane #(
         .M(MODS[g]), .RW(RW),
         .CA(COEF_A[g]), .CB(COEF_B[g]), .CC(COEF_C[g]),
         .CD(COEF_D[g]), .CE(COEF_E[g]),
         .QUAD_FROM_SQ(QUAD_FROM_SQ)
      ) u_lane (
         .clk(clk),
         .x  (in_res[g*RW +: RW]),
         .y  (out_res[g*RW +: RW])
      );

      localparam logic [RW-1:0] K_E   = RW'(COEF_E[g]);
      localparam logic [RW-1:0] K_SUM = RW'((COEF_A[g] + COEF_B[g] + COEF_C[g]
                                             + COEF_D[g] + COEF_E[g]) % MODS[g]);
      localparam logic [RW-1:0] K_MOD = RW'(MODS[g] - 1);

      // R2: digit range
      a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> (out_res[g*RW +: RW] <= K_MOD));
      // R6: zero operand gives constant term
      a_r6_zero_const: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && $past(in_res[g*RW +: RW] == '0, 3)) |-> (out_res[g*RW +: RW] == K_E));
      // R6: unit operand gives coefficient sum
      a_r6_one_sum: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && $past(in_res[g*RW +: RW] == RW'(1), 3)) |-> (out_res[g*RW +: RW] == K_SUM));
   end
endmodule

// File: tb/respoly_act_test.sv
module respoly_act_test;
   localparam int NCH = 4;
   localparam int RW  = 3;
   localparam int BM [NCH] = '{2, 3, 5, 7};
   localparam int NPAT = 12;
   localparam int PATS [NPAT] = '{0, 1, 209, 105, 2, 3, 4, 30, 42, 35, 70, 199};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_vld = 1'b0;
   logic [NCH*RW-1:0] in_res = '0;
   logic              out_vld;
   logic [NCH*RW-1:0] out_res;

   respoly_act uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_res(in_res),
      .out_vld(out_vld), .out_res(out_res)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [NCH*RW-1:0] iss_x [0:1023];
   int                iss_c [0:1023];
   string             iss_t [0:1023];
   int wr = 0;
   int rd = 0;

   function automatic int ref_poly(input int x, input int m);
      return (3*x*x*x*x + 6*x*x*x + 2*x*x + 5*x + 4) % m;
   endfunction

   function automatic logic [NCH*RW-1:0] enc(input int n);
      logic [NCH*RW-1:0] v;
      for (int c = 0; c < NCH; c++) v[c*RW +: RW] = RW'(n % BM[c]);
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic send(input logic [NCH*RW-1:0] v, input string tag);
      @(negedge clk);
      in_vld = 1'b1;
      in_res = v;
      iss_x[wr] = v;
      iss_c[wr] = cyc;
      iss_t[wr] = tag;
      wr++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
         in_res = '0;
      end
   endtask

   // output monitor
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (rd >= wr) begin
            check(1'b0, "R9 unexpected out_vld", 1, 0);
         end else begin
            check(cyc - iss_c[rd] == 3, "R4 latency", cyc - iss_c[rd], 3);
            for (int c = 0; c < NCH; c++) begin
               int xd, yd, ev;
               xd = int'(iss_x[rd][c*RW +: RW]);
               yd = int'(out_res[c*RW +: RW]);
               ev = ref_poly(xd, BM[c]);
               check(yd < BM[c], "R2 digit range", yd, BM[c] - 1);
               check(yd == ev, iss_t[rd], yd, ev);
            end
            rd++;
         end
      end
   end

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20ns * 100000);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      // R7: reset state
      repeat (4) begin
         @(negedge clk);
         check(out_vld == 1'b0, "R7 out_vld low in reset", int'(out_vld), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge clk);
         check(out_vld == 1'b0, "R7 out_vld low after reset", int'(out_vld), 0);
      end

      // R6: directed zero and one
      send(enc(0), "R6 x=0 constant term");
      send(enc(1), "R6 x=1 coefficient sum");
      idle(5);

      // R1 R3 R8: full sweep back to back
      for (int n = 0; n < 210; n++) send(enc(n), "R3 R1 R8 full sweep");
      idle(5);
      check(rd == wr, "R8 all results delivered", rd, wr);

      // R9: table walk with bubbles
      for (int i = 0; i < NPAT; i++) begin
         send(enc(PATS[i]), "R9 table with bubbles");
         idle(1 + (i % 3));
      end
      idle(5);
      check(rd == wr, "R9 result count", rd, wr);

      // R5: vary one channel, hold others
      for (int d = 0; d < 7; d++) begin
         logic [NCH*RW-1:0] v;
         v = {3'd0, 3'd3, 3'd2, 3'd1};
         v[3*RW +: RW] = RW'(d);
         send(v, "R5 channel 3 sweep");
      end
      for (int d = 0; d < 5; d++) begin
         logic [NCH*RW-1:0] v;
         v = {3'd6, 3'd0, 3'd1, 3'd0};
         v[2*RW +: RW] = RW'(d);
         send(v, "R5 channel 2 sweep");
      end
      idle(6);
      check(rd == wr, "R5 result count", rd, wr);
      check(out_vld == 1'b0, "R9 idle tail", int'(out_vld), 0);

      summary();
   end
endmodule